// File: doc/BRIEF.md
# General-Purpose I/O Ports with Indirect Pin Configuration

This block drives and samples 29 general-purpose pins, grouped into byte-wide ports (pin n is port n/8, bit n%8, so the last port carries five pins). Software reaches it through two register paths. A 16-byte runtime window holds data-out, data-in, event-enable and event-status registers. A separate configuration path holds a pin-select register and a per-pin configuration byte. The select register picks one pin, and the configuration byte then reads or writes that pin's output enable, drive type and pull-up.

Each pin produces an output value, an output enable and a pull-up request for its pad. Pad inputs pass through a synchronizer before software can read them. On the two lowest ports, an enabled pin whose synchronized input changes latches a status bit. A single event output is high while any enabled status bit is set.

Top module: `gpio_ind_cfg`

## Requirements
- R1: After reset, every pad output enable, pad output value and pull-up request is 0, the event output is 0, and the data-out, event-enable, event-status, pin-select and configuration reads all return 0.
- R2: The data-out registers sit at offsets 0x00, 0x04, 0x08 and 0x0A for ports 0 to 3. Each reads back the value last written. Bits 7:5 at 0x0A read 0. Offsets 0x0C to 0x0F read 0, and writes to them change no register.
- R3: The data-in registers at 0x01, 0x05, 0x09 and 0x0B show the pad inputs on the second clock edge after a pad change, and not before it. Bits 7:5 at 0x0B read 0.
- R4: Configuration address 0 is the pin-select register. Bits 6:4 hold the port and bits 2:0 hold the bit. It reads back as the written value masked with 0x77.
- R5: Configuration address 1 reads and writes bits 2:0 of the selected pin's configuration byte, and bits 7:3 read 0. When the selection names no existing pin (pin index 29 or more), writes have no effect and reads return 0.
- R6: When configuration bit 0 (output enable) is 0, the pad output enable is 0 whatever the data-out bit holds.
- R7: When output enable is 1 and bit 1 (push-pull) is 1, the pad output enable is 1 and the pad output value follows the data-out bit.
- R8: When output enable is 1 and push-pull is 0 (open-drain), a data-out 0 drives the pad low with its output enable set, and a data-out 1 clears the pad output enable.
- R9: The pad pull-up request equals configuration bit 2, whatever the output enable holds.
- R10: The event-enable registers are at 0x02 (port 0) and 0x06 (port 1), and the event-status registers are at 0x03 and 0x07. A status bit is set on the third clock edge after its pad changes in either direction, but only while its enable bit is 1.
- R11: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a change is detected on the same edge as a clearing write, the bit ends up set.
- R12: The event output is the OR over all status bits whose enable bit is 1. Clearing an enable drops the event output and leaves the status bit as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rt_we_i | input | 1 | Runtime window write strobe |
| rt_addr_i | input | 4 | Runtime window offset for read and write |
| rt_wdata_i | input | 8 | Runtime write data |
| rt_rdata_o | output | 8 | Runtime read data, combinational on rt_addr_i |
| cfg_we_i | input | 1 | Configuration path write strobe |
| cfg_addr_i | input | 1 | 0 selects the pin-select register, 1 the configuration byte |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration read data |
| pad_in_i | input | 29 | Pad input levels |
| pad_out_o | output | 29 | Pad output values |
| pad_oe_o | output | 29 | Pad output enables |
| pad_pu_o | output | 29 | Pad pull-up requests |
| evt_o | output | 1 | Event output |

## Verification
Latching a status bit and clearing it by writing 1 can happen on the same clock edge. The test changes a pad, counts two edges so that the change reaches the detector, and then holds a clearing write so that it lands on the third edge, which is when the status bit would be set. The result is judged by reading the status register afterwards: the bit must still be set, and the event output must stay high until a later clearing write arrives on an edge with no change.

// File: rtl/gpio_ind_pkg.sv
package gpio_ind_pkg;
  localparam int PORT_W = 8;

  typedef struct packed {
    logic pu;   // bit 2
    logic pp;   // bit 1
    logic oe;   // bit 0
  } pin_cfg_t;

  // ports with events use four bytes, the rest two
  function automatic int dout_off(input int p, input int evt_ports);
    return (p < evt_ports) ? 4 * p : 4 * evt_ports + 2 * (p - evt_ports);
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 29,
  parameter int STAGES = 2,
  parameter int EVT_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     pad_i,
  output logic [W-1:0]     sync_o,
  output logic [EVT_W-1:0] chg_o
);
  logic [W-1:0]     stg_q [STAGES];
  logic [EVT_W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= pad_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1][EVT_W-1:0];
    end
  end

  assign sync_o = stg_q[STAGES-1];
  assign chg_o  = stg_q[STAGES-1][EVT_W-1:0] ^ prev_q;
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] chg_i,
  input  logic         en_we_i,
  input  logic         st_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] st_o
);
  logic [W-1:0] en_q, st_q, set_w, clr_w;

  assign set_w = en_q & chg_i;
  assign clr_w = st_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
      st_q <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i;
      st_q <= (st_q & ~clr_w) | set_w;  // set beats clear
    end
  end

  assign en_o = en_q;
  assign st_o = st_q;

  for (genvar b = 0; b < W; b++) begin : g_chk
    a_r10_set_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(st_q[b]) |-> ($past(en_q[b]) && $past(chg_i[b])));
    a_r11_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_we_i && wdata_i[b] && !(en_q[b] && chg_i[b])) |=> !st_q[b]);
    a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_q[b] && chg_i[b]) |=> st_q[b]);
  end
endmodule

// File: rtl/gpio_pin_cfg.sv
module gpio_pin_cfg
  import gpio_ind_pkg::*;
#(
  parameter int NUM_PINS = 29
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic                cfg_addr_i,
  input  logic [7:0]          cfg_wdata_i,
  output logic [7:0]          cfg_rdata_o,
  input  logic [NUM_PINS-1:0] dout_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_pu_o
);
  logic [6:0] sel_q;
  logic [5:0] idx;
  logic       sel_ok;
  pin_cfg_t   cfg_q [NUM_PINS];
  logic       unused_wbits;

  assign unused_wbits = ^{cfg_wdata_i[7], cfg_wdata_i[3]};

  // {port, bit} concatenation is the pin index
  assign idx    = {sel_q[6:4], sel_q[2:0]};
  assign sel_ok = (int'(idx) < NUM_PINS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= '0;
    else if (cfg_we_i && !cfg_addr_i) sel_q <= {cfg_wdata_i[6:4], 1'b0, cfg_wdata_i[2:0]};
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[i] <= '0;
      else if (cfg_we_i && cfg_addr_i && idx == 6'(i)) cfg_q[i] <= cfg_wdata_i[2:0];
    end

    assign pad_oe_o[i]  = cfg_q[i].oe & (cfg_q[i].pp | ~dout_i[i]);
    assign pad_out_o[i] = cfg_q[i].pp & dout_i[i];
    assign pad_pu_o[i]  = cfg_q[i].pu;

    a_r5_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_addr_i && idx == 6'(i)) |=> (cfg_q[i] == $past(cfg_wdata_i[2:0])));
    a_r6_tristate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cfg_q[i].oe |-> !pad_oe_o[i]);
    a_r8_od_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_q[i].pp && dout_i[i]) |-> !pad_oe_o[i]);
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (!cfg_addr_i) cfg_rdata_o = {1'b0, sel_q};
    else if (sel_ok) begin
      for (int i = 0; i < NUM_PINS; i++)
        if (idx == 6'(i)) cfg_rdata_o = {5'b0, cfg_q[i]};
    end
  end
endmodule

// File: rtl/gpio_ind_cfg.sv
module gpio_ind_cfg
  import gpio_ind_pkg::*;
#(
  parameter int NUM_PINS    = 29,
  parameter int EVT_PORTS   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rt_we_i,
  input  logic [ADDR_W-1:0]   rt_addr_i,
  input  logic [7:0]          rt_wdata_i,
  output logic [7:0]          rt_rdata_o,
  input  logic                cfg_we_i,
  input  logic                cfg_addr_i,
  input  logic [7:0]          cfg_wdata_i,
  output logic [7:0]          cfg_rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pad_pu_o,
  output logic                evt_o
);
  localparam int NUM_PORTS = (NUM_PINS + PORT_W - 1) / PORT_W;
  localparam int PAD_W     = NUM_PORTS * PORT_W;
  localparam int EVT_W     = EVT_PORTS * PORT_W;

  function automatic logic [PAD_W-1:0] impl_mask();
    logic [PAD_W-1:0] m;
    for (int i = 0; i < PAD_W; i++) m[i] = (i < NUM_PINS);
    return m;
  endfunction
  localparam logic [PAD_W-1:0] IMPL = impl_mask();

  logic [PAD_W-1:0]    dout_q, din_pad, en_all, st_all;
  logic [NUM_PINS-1:0] din_sync;
  logic [EVT_W-1:0]    chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dout_q <= '0;
    else if (rt_we_i) begin
      for (int p = 0; p < NUM_PORTS; p++)
        if (rt_addr_i == ADDR_W'(dout_off(p, EVT_PORTS)))
          dout_q[p*PORT_W +: PORT_W] <= rt_wdata_i & IMPL[p*PORT_W +: PORT_W];
    end
  end

  gpio_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .EVT_W(EVT_W)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .pad_i(pad_in_i), .sync_o(din_sync), .chg_o(chg)
  );
  assign din_pad = PAD_W'(din_sync);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    if (p < EVT_PORTS) begin : g_evt
      localparam int OFF = dout_off(p, EVT_PORTS);
      gpio_evt_bank #(.W(PORT_W)) u_evt (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .chg_i   (chg[p*PORT_W +: PORT_W]),
        .en_we_i (rt_we_i && rt_addr_i == ADDR_W'(OFF + 2)),
        .st_we_i (rt_we_i && rt_addr_i == ADDR_W'(OFF + 3)),
        .wdata_i (rt_wdata_i),
        .en_o    (en_all[p*PORT_W +: PORT_W]),
        .st_o    (st_all[p*PORT_W +: PORT_W])
      );
    end else begin : g_noevt
      assign en_all[p*PORT_W +: PORT_W] = '0;
      assign st_all[p*PORT_W +: PORT_W] = '0;
    end
  end

  always_comb begin
    rt_rdata_o = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (rt_addr_i == ADDR_W'(dout_off(p, EVT_PORTS)))     rt_rdata_o = dout_q[p*PORT_W +: PORT_W];
      if (rt_addr_i == ADDR_W'(dout_off(p, EVT_PORTS) + 1)) rt_rdata_o = din_pad[p*PORT_W +: PORT_W];
      if (p < EVT_PORTS) begin
        if (rt_addr_i == ADDR_W'(dout_off(p, EVT_PORTS) + 2)) rt_rdata_o = en_all[p*PORT_W +: PORT_W];
        if (rt_addr_i == ADDR_W'(dout_off(p, EVT_PORTS) + 3)) rt_rdata_o = st_all[p*PORT_W +: PORT_W];
      end
    end
  end

  assign evt_o = |(st_all & en_all);

  gpio_pin_cfg #(.NUM_PINS(NUM_PINS)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_addr_i  (cfg_addr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .dout_i      (dout_q[NUM_PINS-1:0]),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o),
    .pad_pu_o    (pad_pu_o)
  );

  a_r2_dout_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_we_i && rt_addr_i == ADDR_W'(dout_off(0, EVT_PORTS)))
      |=> (dout_q[PORT_W-1:0] == $past(rt_wdata_i)));
  a_r2_unimpl_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_q & ~IMPL) == '0);
  a_r12_evt_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (st_all != '0));
endmodule

// File: tb/gpio_ind_cfg_tb.sv
module gpio_ind_cfg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {addr, wdata, expected read}
  localparam logic [19:0] VEC [NV] = '{
    {4'h0, 8'hA5, 8'hA5}, {4'hC, 8'hFF, 8'h00}, {4'h4, 8'h3C, 8'h3C}, {4'h8, 8'hFF, 8'hFF},
    {4'hA, 8'hFF, 8'h1F}, {4'hF, 8'h55, 8'h00}, {4'h4, 8'h81, 8'h81}, {4'h0, 8'h5A, 8'h5A}
  };

  logic        clk = 0, rst_n = 0;
  logic        rt_we = 0, cfg_we = 0, cfg_addr = 0;
  logic [3:0]  rt_addr = 0;
  logic [7:0]  rt_wdata = 0, cfg_wdata = 0, rt_rdata, cfg_rdata;
  logic [28:0] pad_in = '0, pad_out, pad_oe, pad_pu;
  logic        evt;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ind_cfg u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rt_we_i(rt_we), .rt_addr_i(rt_addr), .rt_wdata_i(rt_wdata), .rt_rdata_o(rt_rdata),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .pad_in_i(pad_in), .pad_out_o(pad_out), .pad_oe_o(pad_oe), .pad_pu_o(pad_pu), .evt_o(evt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); rt_we = 1; rt_addr = a; rt_wdata = d;
    @(negedge clk); rt_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rt_addr = a; #1; d = rt_rdata;
  endtask

  task automatic cwr(input logic a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic crd(input logic a, output logic [7:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pad_pu", pad_pu, 0);
    chk("R1 evt", evt, 0);
    rd(4'h0, v); chk("R1 dout0", v, 0);
    rd(4'h7, v); chk("R1 status1", v, 0);
    crd(1'b0, v); chk("R1 select", v, 0);
    crd(1'b1, v); chk("R1 cfg", v, 0);

    // R2 vector table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd(VEC[i][19:16], v);
      chk("R2 table", v, {24'h0, VEC[i][7:0]});
    end
    rd(4'h8, v); chk("R2 no alias of unmapped write", v, 8'hFF);
    rd(4'h4, v); chk("R2 port1 hold", v, 8'h81);

    // R3 input sync
    @(negedge clk); pad_in = 29'h1EC355AA;
    @(negedge clk); rd(4'h1, v); chk("R3 not after one edge", v, 8'h00);
    @(negedge clk);
    rd(4'h1, v); chk("R3 port0", v, 8'hAA);
    rd(4'h5, v); chk("R3 port1", v, 8'h55);
    rd(4'h9, v); chk("R3 port2", v, 8'hC3);
    rd(4'hB, v); chk("R3 port3 masked", v, 8'h1E);

    // R4 select encoding
    cwr(1'b0, 8'hFF); crd(1'b0, v); chk("R4 select mask", v, 8'h77);
    // R5 invalid pin 29
    cwr(1'b0, 8'h35); cwr(1'b1, 8'h07);
    crd(1'b1, v); chk("R5 invalid read", v, 0);
    chk("R5 invalid no effect", pad_oe | pad_pu, 0);
    // pin 28: oe, pp, pu; dout port3 = 1F
    cwr(1'b0, 8'h34); cwr(1'b1, 8'hFF);
    crd(1'b1, v); chk("R5 cfg read", v, 8'h07);
    #1;
    chk("R7 pp oe", pad_oe[28], 1);
    chk("R7 pp out high", pad_out[28], 1);
    chk("R9 pu", pad_pu[28], 1);
    wr(4'hA, 8'h0F); #1;
    chk("R7 pp out low", pad_out[28], 0);
    chk("R7 pp oe held", pad_oe[28], 1);
    // pin 9 open-drain; port1 dout 0x81 bit1=0
    cwr(1'b0, 8'h11); cwr(1'b1, 8'h01); #1;
    chk("R8 od drive low oe", pad_oe[9], 1);
    chk("R8 od drive low out", pad_out[9], 0);
    wr(4'h4, 8'h83); #1;
    chk("R8 od release", pad_oe[9], 0);
    // pin 0 tristate with pp and pu; dout bit0=1
    wr(4'h0, 8'hA5);
    cwr(1'b0, 8'h00); cwr(1'b1, 8'h06); #1;
    chk("R6 tristate", pad_oe[0], 0);
    chk("R9 pu without oe", pad_pu[0], 1);
    chk("R6 oe vector", pad_oe, 29'h10000000);

    // R10 event on port0 bit0, bit1 disabled
    wr(4'h2, 8'h01);
    @(negedge clk); pad_in = pad_in ^ 29'h3;
    @(negedge clk); rd(4'h3, v); chk("R10 not yet 1", v, 0);
    @(negedge clk); rd(4'h3, v); chk("R10 not yet 2", v, 0);
    @(negedge clk); rd(4'h3, v); chk("R10 set enabled only", v, 8'h01);
    chk("R12 evt high", evt, 1);
    wr(4'h2, 8'h00); #1;
    chk("R12 evt off when disabled", evt, 0);
    rd(4'h3, v); chk("R12 status kept", v, 8'h01);
    wr(4'h3, 8'h00); rd(4'h3, v); chk("R11 write 0 no effect", v, 8'h01);
    wr(4'h3, 8'h01); rd(4'h3, v); chk("R11 w1c", v, 0);

    // R11 set wins over clear on same edge, port1 bit7
    wr(4'h6, 8'h80);
    @(negedge clk); pad_in = pad_in ^ 29'h8000;
    @(negedge clk);
    @(negedge clk); rt_we = 1; rt_addr = 4'h7; rt_wdata = 8'h80;
    @(negedge clk); rt_we = 0;
    rd(4'h7, v); chk("R11 set wins", v, 8'h80);
    chk("R12 evt from port1", evt, 1);
    wr(4'h7, 8'h80); rd(4'h7, v); chk("R11 later clear", v, 0);
    chk("R12 evt low", evt, 0);
    // R10 falling edge
    @(negedge clk); pad_in = pad_in ^ 29'h8000;
    repeat (3) @(negedge clk);
    rd(4'h7, v); chk("R10 falling edge", v, 8'h80);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule